// File: doc/BRIEF.md
# Compare-Match Periodic Timer Channel

This block is one 16-bit timer channel controlled through a small byte-addressed register file. A prescaler derives counting ticks from the system clock. On each tick the up-counter advances while the channel is running. The channel's run bit arrives on `run_en` from a start register outside the block that holds one bit per channel. Compare register A either matches against the counter or, in capture mode, samples it on an edge of `cap_in`.

When compare A is chosen as the clear source, the counter returns to zero on the matching tick, which gives a periodic event every compare A + 1 ticks. A 4-bit pin-action field sets the compare output `cmp_out` to a starting level and then clears, sets or toggles it on each match. Two status flags record compare/capture and counter overflow. Each flag is cleared only by a read-then-write-zero sequence. `irq` is raised while an enabled flag is set.

Top module: `cmp_timer_chan`

## Requirements
- R1: After synchronous reset every register reads 0, the counter is 0, and `cmp_out` and `irq` are 0.
- R2: Registers are at these byte addresses: control 0, mode 1, pin control 2, interrupt enable 4, status 5, counter 6 (16-bit), compare A 8 (16-bit). Each reads back what was written, except status. Status reads only bit 0 (compare/capture flag) and bit 4 (overflow flag). Every other address reads 0.
- R3: Control bits 2:0 pick the divider: 0 → 1, 1 → 4, 2 → 16, 3 → 64, 4 to 7 → no ticks. Control bits 4:3 pick the prescaler edge: 0 rising, 1 falling, 2 or 3 both. The prescaler phase restarts at 0 whenever `run_en` is 0.
- R4: The counter advances only on ticks taken while `run_en` is 1 and the mode register is 0. Otherwise it holds its value.
- R5: When control bits 7:5 equal 1, a match tick loads the counter with 0 instead of incrementing it. The period is then compare A + 1 ticks. Every other value of bits 7:5 gives no clear.
- R6: A tick on which the counter equals compare A, taken in compare mode, sets status bit 0. A tick that takes the counter from 0xFFFF to 0 sets status bit 4.
- R7: A flag clears only when a status write with 0 in its bit follows a status read that saw the flag set. No other status access may come between the read and that write. Writing 1 never clears a flag.
- R8: `irq` is 1 exactly while (status bit 0 and enable bit 0) or (status bit 4 and enable bit 4) are both 1.
- R9: Pin control bits 3:0 set the pin action. Writing 1, 2 or 3 sets `cmp_out` to 0 at once; 5, 6 or 7 sets it to 1. On later matches codes 1/5 clear, 2/6 set and 3/7 toggle the output. Code 0 or 4 holds it.
- R10: Pin control codes 8, 9 and 10 select capture on a rising, falling or either edge of `cap_in`. The input passes a two-flop synchronizer. A detected edge loads the counter into compare A and sets status bit 0. `cmp_out` is not changed in capture mode.
- R11: A bus write to the counter takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | This channel's bit from the shared start register |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 16 | Write data; 8-bit registers use bits 7:0 |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| cap_in | input | 1 | Capture input pin (asynchronous) |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are not asserted together. They also assume that the divider and edge fields are not rewritten on the cycle after a tick, since a rewrite could legally place two ticks back to back. The bench issues one bus access at a time and changes the control register only while `run_en` is low. Each scenario starts from reset so that the prescaler phase is known. `cap_in` is driven away from the clock edge and held for several cycles, so every edge passes the synchronizer cleanly.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int CNT_W        = 16;
    localparam int REG_W        = 8;
    localparam int ADDR_W       = 4;
    localparam int DIV_LOG2_MAX = 6;
    localparam int PS_W         = DIV_LOG2_MAX;
    localparam int NFLAG        = 2;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] OFF_MODE   = 4'd1;
    localparam logic [ADDR_W-1:0] OFF_PINCTL = 4'd2;
    localparam logic [ADDR_W-1:0] OFF_IEN    = 4'd4;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 4'd5;
    localparam logic [ADDR_W-1:0] OFF_CNT    = 4'd6;
    localparam logic [ADDR_W-1:0] OFF_CMPA   = 4'd8;

    localparam int FLG_CMP = 0;
    localparam int FLG_OVF = 4;
    localparam logic [2:0] CLR_ON_CMPA = 3'd1;

    typedef enum logic [1:0] {EDGE_RISE = 2'd0, EDGE_FALL = 2'd1,
                              EDGE_BOTH = 2'd2, EDGE_BOTH2 = 2'd3} edge_e;
    typedef enum logic [1:0] {ACT_HOLD = 2'd0, ACT_CLR = 2'd1,
                              ACT_SET = 2'd2, ACT_TGL = 2'd3} act_e;

    typedef struct packed {
        logic [2:0] clr_sel;
        edge_e      edge_sel;
        logic [2:0] div_sel;
    } ctrl_t;

    typedef struct packed {
        logic       capture;
        logic [1:0] cap_edges;   // bit0 rising, bit1 falling
        logic       init_valid;
        logic       init_lvl;
        act_e       act;
    } pin_cfg_t;

    function automatic pin_cfg_t decode_pin(input logic [3:0] code);
        pin_cfg_t c;
        c = '0;
        if (!code[3]) begin
            c.act        = act_e'(code[1:0]);
            c.init_valid = (code[1:0] != 2'd0);
            c.init_lvl   = code[2];
        end else begin
            c.capture = 1'b1;
            case (code[2:0])
                3'd0:    c.cap_edges = 2'b01;
                3'd1:    c.cap_edges = 2'b10;
                3'd2:    c.cap_edges = 2'b11;
                default: c.cap_edges = 2'b00;
            endcase
        end
        return c;
    endfunction

    function automatic logic pin_next(input act_e a, input logic cur);
        case (a)
            ACT_CLR: return 1'b0;
            ACT_SET: return 1'b1;
            ACT_TGL: return ~cur;
            default: return cur;
        endcase
    endfunction

    // Tick when the selected divided-clock bit makes the chosen transition.
    function automatic logic tick_fn(input logic [2:0] div, input edge_e e,
                                     input logic [PS_W-1:0] ph);
        int b;
        logic [PS_W-1:0] full_m, half_m;
        if (div == 3'd0) return 1'b1;
        if (div > 3'd3)  return 1'b0;
        b      = 2 * int'(div) - 1;
        full_m = PS_W'((1 << (b + 1)) - 1);
        half_m = PS_W'((1 << b) - 1);
        case (e)
            EDGE_RISE: return (ph & full_m) == half_m;
            EDGE_FALL: return (ph & full_m) == full_m;
            default:   return (ph & half_m) == half_m;
        endcase
    endfunction
endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale import cmt_pkg::*; #(
    parameter int PW = PS_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] div_sel,
    input  edge_e      edge_sel,
    output logic       tick
);
    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !run) phase <= '0;
        else             phase <= phase + 1'b1;
    end

    assign tick = run && tick_fn(div_sel, edge_sel, phase);

    AST_DIV_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (tick && div_sel != 3'd0) |=> (!tick || !$stable(div_sel) || !$stable(edge_sel))); // R3
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter import cmt_pkg::*; #(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         count_en,
    input  logic         cmp_mode,
    input  logic         clr_on_a,
    input  logic         wr_cnt,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cmpa,
    output logic [W-1:0] cnt,
    output logic         match_evt,
    output logic         ovf_evt
);
    logic adv, wrap;

    assign adv       = tick && count_en;
    assign match_evt = adv && cmp_mode && (cnt == cmpa);
    assign wrap      = match_evt && clr_on_a;
    assign ovf_evt   = adv && !wrap && (&cnt);

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (wr_cnt) cnt <= wdata;
        else if (wrap)   cnt <= '0;
        else if (adv)    cnt <= cnt + 1'b1;
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (match_evt && clr_on_a && !wr_cnt) |=> (cnt == '0)); // R5
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        (!(tick && count_en) && !wr_cnt) |=> $stable(cnt)); // R4
    AST_BUS_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (cnt == $past(wdata))); // R11
endmodule

// File: rtl/cmt_capture.sv
module cmt_capture (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_en,
    input  logic fall_en,
    output logic cap_evt
);
    logic [2:0] sh;   // two synchronizer stages plus previous sample

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], pin};
    end

    assign cap_evt = (rise_en && sh[1] && !sh[2]) || (fall_en && !sh[1] && sh[2]);

    AST_ONE_CAPTURE_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> !cap_evt); // R10
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan import cmt_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              cap_in,
    output logic              cmp_out,
    output logic              irq
);
    localparam int FLAG_POS [NFLAG] = '{FLG_CMP, FLG_OVF};

    ctrl_t            ctrl_q;
    logic [REG_W-1:0] mode_q, pinctl_q, ien_q, stat_byte;
    logic [CNT_W-1:0] cmpa_q, cnt;
    logic             pin_q, tick, match_evt, ovf_evt, cap_evt;
    pin_cfg_t         pin_cfg, new_cfg;
    logic [NFLAG-1:0] flag_q, flag_set, ien_bits;

    logic ctrl_wr, mode_wr, pinctl_wr, ien_wr, stat_wr, stat_rd, cnt_wr, cmpa_wr;
    assign ctrl_wr   = bus_wr && bus_addr == OFF_CTRL;
    assign mode_wr   = bus_wr && bus_addr == OFF_MODE;
    assign pinctl_wr = bus_wr && bus_addr == OFF_PINCTL;
    assign ien_wr    = bus_wr && bus_addr == OFF_IEN;
    assign stat_wr   = bus_wr && bus_addr == OFF_STAT;
    assign cnt_wr    = bus_wr && bus_addr == OFF_CNT;
    assign cmpa_wr   = bus_wr && bus_addr == OFF_CMPA;
    assign stat_rd   = bus_rd && bus_addr == OFF_STAT;

    assign pin_cfg = decode_pin(pinctl_q[3:0]);
    assign new_cfg = decode_pin(bus_wdata[3:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            mode_q   <= '0;
            pinctl_q <= '0;
            ien_q    <= '0;
            cmpa_q   <= '0;
        end else begin
            if (ctrl_wr)      ctrl_q   <= ctrl_t'(bus_wdata[REG_W-1:0]);
            if (mode_wr)      mode_q   <= bus_wdata[REG_W-1:0];
            if (pinctl_wr)    pinctl_q <= bus_wdata[REG_W-1:0];
            if (ien_wr)       ien_q    <= bus_wdata[REG_W-1:0];
            if (cmpa_wr)      cmpa_q   <= bus_wdata;
            else if (cap_evt) cmpa_q   <= cnt;
        end
    end

    cmt_prescale u_pre (
        .clk(clk), .rst(rst), .run(run_en),
        .div_sel(ctrl_q.div_sel), .edge_sel(ctrl_q.edge_sel), .tick(tick)
    );

    cmt_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .count_en(mode_q == '0),
        .cmp_mode(!pin_cfg.capture), .clr_on_a(ctrl_q.clr_sel == CLR_ON_CMPA),
        .wr_cnt(cnt_wr), .wdata(bus_wdata), .cmpa(cmpa_q),
        .cnt(cnt), .match_evt(match_evt), .ovf_evt(ovf_evt)
    );

    cmt_capture u_cap (
        .clk(clk), .rst(rst), .pin(cap_in),
        .rise_en(pin_cfg.capture && pin_cfg.cap_edges[0]),
        .fall_en(pin_cfg.capture && pin_cfg.cap_edges[1]),
        .cap_evt(cap_evt)
    );

    assign flag_set = {ovf_evt, match_evt || cap_evt};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        logic f_q, armed_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                f_q     <= 1'b0;
                armed_q <= 1'b0;
            end else begin
                if (flag_set[g])
                    f_q <= 1'b1;
                else if (stat_wr && armed_q && !bus_wdata[FLAG_POS[g]])
                    f_q <= 1'b0;
                if (stat_wr)               armed_q <= 1'b0;
                else if (stat_rd && f_q)   armed_q <= 1'b1;
            end
        end
        assign flag_q[g]   = f_q;
        assign ien_bits[g] = ien_q[FLAG_POS[g]];
    end

    assign irq = |(flag_q & ien_bits);

    always_ff @(posedge clk) begin
        if (rst)
            pin_q <= 1'b0;
        else if (pinctl_wr) begin
            if (!new_cfg.capture && new_cfg.init_valid) pin_q <= new_cfg.init_lvl;
        end else if (match_evt)
            pin_q <= pin_next(pin_cfg.act, pin_q);
    end
    assign cmp_out = pin_q;

    always_comb begin
        stat_byte = '0;
        for (int i = 0; i < NFLAG; i++) stat_byte[FLAG_POS[i]] = flag_q[i];
        case (bus_addr)
            OFF_CTRL:   bus_rdata = {8'h00, ctrl_q};
            OFF_MODE:   bus_rdata = {8'h00, mode_q};
            OFF_PINCTL: bus_rdata = {8'h00, pinctl_q};
            OFF_IEN:    bus_rdata = {8'h00, ien_q};
            OFF_STAT:   bus_rdata = {8'h00, stat_byte};
            OFF_CNT:    bus_rdata = cnt;
            OFF_CMPA:   bus_rdata = cmpa_q;
            default:    bus_rdata = '0;
        endcase
    end

    AST_WRITE_ONE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && bus_wdata[FLG_CMP] && flag_q[0]) |=> flag_q[0]); // R7
    AST_FLAG_FALLS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q[0]) |-> $past(stat_wr)); // R7
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_q != '0)); // R8
    AST_PIN_STILL_IN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (pin_cfg.capture && !pinctl_wr) |=> $stable(pin_q)); // R10
    AST_CAPTURE_LOADS_CMPA: assert property (@(posedge clk) disable iff (rst)
        (cap_evt && !cmpa_wr) |=> (cmpa_q == $past(cnt))); // R10
    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd)); // R2
endmodule

// File: tb/cmp_timer_chan_tb.sv
module cmp_timer_chan_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, cap_in = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cmp_out, irq;
    int          checks = 0, errors = 0;
    bit          done = 0;
    logic [15:0] rv;

    cmp_timer_chan u_dut (
        .clk(clk), .rst(rst), .run_en(run_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq)
    );

    always #4 clk = ~clk;

    localparam int NV = 9;
    localparam logic [7:0]  V_CTRL [NV] = '{8'h00, 8'h01, 8'h09, 8'h11, 8'h02, 8'h0A, 8'h03, 8'h13, 8'h05};
    localparam int          V_CYC  [NV] = '{40, 40, 40, 40, 64, 64, 128, 128, 40};
    localparam logic [15:0] V_EXP  [NV] = '{16'd40, 16'd10, 16'd10, 16'd20, 16'd4, 16'd4, 16'd2, 16'd4, 16'd0};

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; run_en = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; cap_in = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run_for(input int n);
        @(negedge clk);
        run_en = 1'b1;
        repeat (n) @(negedge clk);
        run_en = 1'b0;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), rv);
            chk("R1 register reset", rv, 16'h0000);
        end
        chk("R1 cmp_out reset", {15'd0, cmp_out}, 16'd0);
        chk("R1 irq reset", {15'd0, irq}, 16'd0);

        // R3 prescaler table
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(4'd0, {8'h00, V_CTRL[i]});
            run_for(V_CYC[i]);
            rd(4'd6, rv);
            chk($sformatf("R3 divider vector %0d", i), rv, V_EXP[i]);
        end

        // R2 readback
        do_reset();
        wr(4'd0, 16'h005B); wr(4'd1, 16'h000C); wr(4'd2, 16'h0096);
        wr(4'd4, 16'h0011); wr(4'd6, 16'hBEEF); wr(4'd8, 16'h1234);
        rd(4'd0, rv); chk("R2 control", rv, 16'h005B);
        rd(4'd1, rv); chk("R2 mode", rv, 16'h000C);
        rd(4'd2, rv); chk("R2 pin control", rv, 16'h0096);
        rd(4'd4, rv); chk("R2 enable", rv, 16'h0011);
        rd(4'd6, rv); chk("R2 counter", rv, 16'hBEEF);
        rd(4'd8, rv); chk("R2 compare A", rv, 16'h1234);
        rd(4'd3, rv); chk("R2 unused address", rv, 16'h0000);
        rd(4'd5, rv); chk("R2 status idle", rv, 16'h0000);

        // R4 mode nonzero and run low hold the counter
        do_reset();
        wr(4'd1, 16'h0002);
        run_for(10);
        rd(4'd6, rv); chk("R4 mode nonzero holds", rv, 16'd0);
        do_reset();
        run_for(5);
        repeat (10) @(negedge clk);
        rd(4'd6, rv); chk("R4 run low holds", rv, 16'd5);

        // R5 / R6 clear on compare A, R8 irq
        do_reset();
        wr(4'd8, 16'd4); wr(4'd0, 16'h0020);
        run_for(12);
        rd(4'd6, rv); chk("R5 wrap at compare A", rv, 16'd2);
        rd(4'd5, rv); chk("R6 compare flag", rv, 16'h0001);
        chk("R8 irq masked", {15'd0, irq}, 16'd0);
        wr(4'd4, 16'h0001);
        chk("R8 irq compare enabled", {15'd0, irq}, 16'd1);
        do_reset();
        wr(4'd8, 16'd4); wr(4'd0, 16'h0040);
        run_for(12);
        rd(4'd6, rv); chk("R5 other clear source no clear", rv, 16'd12);

        // R6 overflow, R8, R7 flag clear sequence
        do_reset();
        wr(4'd8, 16'h8000); wr(4'd6, 16'hFFFE);
        run_for(3);
        rd(4'd6, rv); chk("R6 counter after overflow", rv, 16'd1);
        chk("R8 irq overflow masked", {15'd0, irq}, 16'd0);
        wr(4'd4, 16'h0010);
        chk("R8 irq overflow enabled", {15'd0, irq}, 16'd1);
        rd(4'd5, rv); chk("R6 overflow flag", rv, 16'h0010);
        wr(4'd5, 16'h0010);
        chk("R7 write one keeps flag", {15'd0, irq}, 16'd1);
        wr(4'd5, 16'h0000);
        chk("R7 unarmed write zero keeps flag", {15'd0, irq}, 16'd1);
        rd(4'd5, rv);
        wr(4'd5, 16'h0000);
        chk("R7 read then write zero clears", {15'd0, irq}, 16'd0);
        rd(4'd5, rv); chk("R7 status after clear", rv, 16'h0000);

        // R9 pin actions
        do_reset();
        wr(4'd2, 16'h0005);
        chk("R9 code 5 starts high", {15'd0, cmp_out}, 16'd1);
        wr(4'd2, 16'h0003);
        chk("R9 code 3 starts low", {15'd0, cmp_out}, 16'd0);
        wr(4'd8, 16'd2); wr(4'd0, 16'h0020);
        run_for(3);
        chk("R9 toggle on first match", {15'd0, cmp_out}, 16'd1);
        run_for(5);
        chk("R9 toggle on second match", {15'd0, cmp_out}, 16'd0);
        do_reset();
        wr(4'd2, 16'h0002);
        wr(4'd8, 16'd2); wr(4'd0, 16'h0020);
        run_for(3);
        chk("R9 set on match", {15'd0, cmp_out}, 16'd1);
        wr(4'd2, 16'h0000);
        run_for(6);
        chk("R9 code 0 holds", {15'd0, cmp_out}, 16'd1);

        // R10 capture
        do_reset();
        wr(4'd6, 16'h0100); wr(4'd2, 16'h0008);
        @(negedge clk); cap_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(4'd8, rv); chk("R10 rising capture value", rv, 16'h0100);
        rd(4'd5, rv); chk("R10 capture flag", rv, 16'h0001);
        chk("R10 pin unchanged", {15'd0, cmp_out}, 16'd0);
        wr(4'd2, 16'h0009); wr(4'd6, 16'h0200);
        @(negedge clk); cap_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(4'd8, rv); chk("R10 falling capture value", rv, 16'h0200);
        wr(4'd6, 16'h0300);
        @(negedge clk); cap_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(4'd8, rv); chk("R10 wrong edge ignored", rv, 16'h0200);

        // R11 bus write beats tick
        do_reset();
        @(negedge clk);
        run_en = 1'b1; bus_wr = 1'b1; bus_addr = 4'd6; bus_wdata = 16'h0050;
        @(negedge clk);
        run_en = 1'b0; bus_wr = 1'b0;
        rd(4'd6, rv); chk("R11 write priority", rv, 16'h0050);

        done = 1;
        report();
    end
endmodule